// File: doc/BRIEF.md
# Per-Pin Digital Input Glitch Filter

This block sits between a bank of raw input pins and the logic that consumes them. Each pin has its own filter, which passes the pin's level onward only after that level has stayed steady for a programmable number of filter-clock ticks. Pulses shorter than that window are removed. Every pin is first brought into the filter domain through a two-stage synchronizer.

The filters share one tick source. A selector picks between two sources. The first is the bus clock, which gives a tick on every cycle. The second is a slow low-power tick, supplied as a single-cycle enable pulse on the bus clock, so the design stays in one clock domain.

Software sets up the block through three registers on a simple read/write port:

- An enable mask with one bit per pin.
- The clock selector. It is locked while any filter is enabled.
- The filter width.

A filter drives its output only when its enable bit is set and the pin's mode qualifier marks the pin as a digital input. In every other case the output is held low.

Top module: `pin_glitch_filter`

## Requirements
- R1: After reset every filtered output is 0, and the enable, clock-select and width registers all read 0.
- R2: While a pin's enable bit is 0, its filtered output is 0. The output also returns to 0 on the clock edge that follows the clearing of that bit.
- R3: Enable bit i (register address 0, bits NUM_PINS-1:0) controls pin i only. Clearing one bit leaves the outputs of the other pins unchanged.
- R4: When an active filter has width N > 0 and the bus clock is selected, the output follows its input as follows. A raw level that is first present at clock edge k reaches the output at edge k+1+N. This holds if the level stays steady until then.
- R5: A pin whose digital-input qualifier is 0 is treated as disabled, and its output is held at 0.
- R6: A width of 0 bypasses the filter. The output then tracks the synchronized input, and a raw level first present at edge k appears at the output at edge k+2.
- R7: Clock select 0 (address 1, bit 0) makes the filter advance on every bus cycle. Clock select 1 makes the synchronizer and the counters advance only on cycles where slowTick is high.
- R8: A write to the clock-select register is ignored while any enable bit is 1.
- R9: Register map and unused bits:
  - Address 2 holds the width in bits WIDTH_BITS-1:0.
  - Bits 31:1 of the clock-select register read as 0.
  - Width bits at or above WIDTH_BITS read as 0.
  - Enable bits at or above NUM_PINS read as 0.
  - Address 3 reads as 0.
- R10: The stability count restarts whenever the synchronized input equals the current output. As a result, a pulse that lasts fewer than N ticks never reaches the output.
- R11: When the block is built with HAS_FILTER = 0, every register reads 0, all writes are ignored, and all outputs stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slowTick | input | 1 | Single-cycle pulse that marks a low-power clock tick |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 enable, 1 clock select, 2 width) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| pinRaw | input | NUM_PINS | Raw pin levels |
| pinIsDigIn | input | NUM_PINS | Per-pin qualifier: 1 when the pin is a digital input |
| pinFilt | output | NUM_PINS | Filtered pin levels |

## Verification
The main instance uses four pins and a four-bit width. With these values, all enable-mask patterns are small enough to reach, and the width-overflow read-back (R9) can be seen in a 32-bit read. The slow tick is pulsed once every 16 cycles, so a two-tick window in slow mode is clearly longer than the same window on the bus clock. A second instance is built with HAS_FILTER = 0 and receives the same stimulus, which exercises the read-only, all-zero variant.

// File: rtl/pgf_pkg.sv
package pgf_pkg;
  typedef enum logic [1:0] {
    ADDR_ENABLE = 2'd0,
    ADDR_CLKSEL = 2'd1,
    ADDR_WIDTH  = 2'd2,
    ADDR_SPARE  = 2'd3
  } regAddr_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;    // filter domain advances this cycle
    logic bypass;  // width register is zero
  } filtStrobe_t;
endpackage

// File: rtl/pgf_ctrl.sv
module pgf_ctrl
  import pgf_pkg::*;
#(
  parameter int NUM_PINS   = 8,
  parameter int WIDTH_BITS = 5,
  parameter bit HAS_FILTER = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  slowTick,
  input  logic                  regWrEn,
  input  logic [1:0]            regAddr,
  input  logic [31:0]           regWrData,
  output logic [31:0]           regRdData,
  output logic [NUM_PINS-1:0]   enMask,
  output logic                  clkSel,
  output logic [WIDTH_BITS-1:0] width,
  output filtStrobe_t           strobe
);
  regAddr_e addrDec;
  assign addrDec = regAddr_e'(regAddr);

  generate
    if (HAS_FILTER) begin : g_regs
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          enMask <= '0;
          clkSel <= 1'b0;
          width  <= '0;
        end else if (regWrEn) begin
          case (addrDec)
            ADDR_ENABLE: enMask <= regWrData[NUM_PINS-1:0];
            // source change only legal with every filter off
            ADDR_CLKSEL: if (enMask == '0) clkSel <= regWrData[0];
            ADDR_WIDTH:  width <= regWrData[WIDTH_BITS-1:0];
            default: ;
          endcase
        end
      end
    end else begin : g_noregs
      logic unusedInputs;
      assign unusedInputs = ^{clk, rst_n, regWrEn, regWrData, slowTick};
      assign enMask = '0;
      assign clkSel = 1'b0;
      assign width  = '0;
    end
  endgenerate

  always_comb begin
    regRdData = '0;
    case (addrDec)
      ADDR_ENABLE: regRdData[NUM_PINS-1:0]   = enMask;
      ADDR_CLKSEL: regRdData[0]              = clkSel;
      ADDR_WIDTH:  regRdData[WIDTH_BITS-1:0] = width;
      default:     regRdData = '0;
    endcase
  end

  assign strobe.tick   = clkSel ? slowTick : 1'b1;
  assign strobe.bypass = (width == '0);
endmodule

// File: rtl/pgf_datapath.sv
module pgf_datapath
  import pgf_pkg::*;
#(
  parameter int NUM_PINS   = 8,
  parameter int WIDTH_BITS = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  filtStrobe_t           strobe,
  input  logic [WIDTH_BITS-1:0] width,
  input  logic [NUM_PINS-1:0]   enMask,
  input  logic [NUM_PINS-1:0]   pinIsDigIn,
  input  logic [NUM_PINS-1:0]   pinRaw,
  output logic [NUM_PINS-1:0]   pinFilt
);
  localparam logic [WIDTH_BITS-1:0] ONE = WIDTH_BITS'(1);

  logic [NUM_PINS-1:0] syncA, syncB;
  logic [WIDTH_BITS-1:0] lastCount;

  assign lastCount = width - ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncA <= '0;
      syncB <= '0;
    end else if (strobe.tick) begin
      syncA <= pinRaw;
      syncB <= syncA;
    end
  end

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic [WIDTH_BITS-1:0] count;
      logic                  level;
      logic                  active;

      assign active = enMask[i] & pinIsDigIn[i];

      always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
          count <= '0;
          level <= 1'b0;
        end else if (strobe.tick) begin
          if (strobe.bypass) begin
            level <= syncB[i];
            count <= '0;
          end else if (syncB[i] == level) begin
            count <= '0;
          end else if (count >= lastCount) begin
            level <= syncB[i];
            count <= '0;
          end else begin
            count <= count + ONE;
          end
        end
      end

      assign pinFilt[i] = level;
    end
  endgenerate
endmodule

// File: rtl/pin_glitch_filter.sv
module pin_glitch_filter
  import pgf_pkg::*;
#(
  parameter int NUM_PINS   = 8,
  parameter int WIDTH_BITS = 5,
  parameter bit HAS_FILTER = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slowTick,
  input  logic                regWrEn,
  input  logic [1:0]          regAddr,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData,
  input  logic [NUM_PINS-1:0] pinRaw,
  input  logic [NUM_PINS-1:0] pinIsDigIn,
  output logic [NUM_PINS-1:0] pinFilt
);
  logic [NUM_PINS-1:0]   enMask;
  logic                  clkSel;
  logic [WIDTH_BITS-1:0] width;
  filtStrobe_t           strobe;
  logic                  strobeTick;

  assign strobeTick = strobe.tick;

  pgf_ctrl #(
    .NUM_PINS(NUM_PINS), .WIDTH_BITS(WIDTH_BITS), .HAS_FILTER(HAS_FILTER)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .slowTick(slowTick),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .enMask(enMask), .clkSel(clkSel),
    .width(width), .strobe(strobe)
  );

  pgf_datapath #(
    .NUM_PINS(NUM_PINS), .WIDTH_BITS(WIDTH_BITS)
  ) u_data (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .width(width),
    .enMask(enMask), .pinIsDigIn(pinIsDigIn), .pinRaw(pinRaw),
    .pinFilt(pinFilt)
  );
endmodule

// File: rtl/pgf_checker.sv
module pgf_checker #(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic                clkSel,
  input logic [NUM_PINS-1:0] enMask,
  input logic [NUM_PINS-1:0] pinIsDigIn,
  input logic [NUM_PINS-1:0] pinFilt,
  input logic [1:0]          regAddr,
  input logic [31:0]         regRdData
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (pinFilt == '0 && enMask == '0 && clkSel == 1'b0));

  // R2, R3, R5: a high output needs an active filter one edge before
  p_inactive_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pinFilt & ~$past(enMask & pinIsDigIn)) == '0));

  p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && ((enMask & pinIsDigIn) == '1)) |=> $stable(pinFilt));

  p_sel_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|enMask) |=> $stable(clkSel));

  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (regAddr == 2'd1) |-> (regRdData[31:1] == '0));
endmodule

bind pin_glitch_filter pgf_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(strobeTick), .clkSel(clkSel),
  .enMask(enMask), .pinIsDigIn(pinIsDigIn), .pinFilt(pinFilt),
  .regAddr(regAddr), .regRdData(regRdData)
);

// File: tb/sim_pin_glitch_filter.sv
`timescale 1ns/100ps
module sim_pin_glitch_filter;
  localparam int NP = 4;
  localparam int WB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slowTick = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData, rdNoFilt;
  logic [NP-1:0] pinRaw = '0;
  logic [NP-1:0] pinIsDigIn = '0;
  logic [NP-1:0] pinFilt, filtNoFilt;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pin_glitch_filter #(.NUM_PINS(NP), .WIDTH_BITS(WB), .HAS_FILTER(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .slowTick(slowTick), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .pinRaw(pinRaw), .pinIsDigIn(pinIsDigIn), .pinFilt(pinFilt));

  pin_glitch_filter #(.NUM_PINS(NP), .WIDTH_BITS(WB), .HAS_FILTER(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .slowTick(slowTick), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(rdNoFilt),
    .pinRaw(pinRaw), .pinIsDigIn(pinIsDigIn), .pinFilt(filtNoFilt));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // slow low-power tick: one pulse every 16 bus cycles
  int slowCnt = 0;
  always @(negedge clk) begin
    slowCnt <= (slowCnt + 1) % 16;
    slowTick <= (slowCnt == 15);
  end

  // behavioural reference model
  logic [NP-1:0] mEn, mS1, mS2, mOut;
  logic mSel;
  int mWidth;
  int mCnt [NP];

  always @(posedge clk) begin
    if (!rst_n) begin
      mEn = '0; mSel = 1'b0; mWidth = 0; mS1 = '0; mS2 = '0; mOut = '0;
      for (int i = 0; i < NP; i++) mCnt[i] = 0;
    end else begin
      bit tk;
      tk = mSel ? slowTick : 1'b1;
      for (int i = 0; i < NP; i++) begin
        if (!(mEn[i] && pinIsDigIn[i])) begin
          mCnt[i] = 0; mOut[i] = 1'b0;
        end else if (tk) begin
          if (mWidth == 0) begin
            mOut[i] = mS2[i]; mCnt[i] = 0;
          end else if (mS2[i] == mOut[i]) begin
            mCnt[i] = 0;
          end else begin
            mCnt[i]++;
            if (mCnt[i] >= mWidth) begin mOut[i] = mS2[i]; mCnt[i] = 0; end
          end
        end
      end
      if (tk) begin mS2 = mS1; mS1 = pinRaw; end
      if (regWrEn) begin
        case (regAddr)
          2'd0: mEn = regWrData[NP-1:0];
          2'd1: if (mEn == '0) mSel = regWrData[0];
          2'd2: mWidth = int'(regWrData[WB-1:0]);
          default: ;
        endcase
      end
    end
  end

  // compare against the model on every clock
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) check("R4 model", {28'd0, pinFilt}, {28'd0, mOut});
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [31:0] exp);
    regAddr = a;
    #0.2;
    check(req, regRdData, exp);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    rd("R1 enable", 2'd0, 32'd0);
    rd("R1 clksel", 2'd1, 32'd0);
    rd("R1 width", 2'd2, 32'd0);
    check("R1 outputs", {28'd0, pinFilt}, 32'd0);

    wr(2'd2, 32'd3);
    wr(2'd0, 32'hF);
    pinIsDigIn = 4'hF;
    cyc(10);

    // R4 latency with N=3: raw present at edge k, output at edge k+4
    pinRaw[0] = 1'b1;
    cyc(4);
    check("R4 before window", {31'd0, pinFilt[0]}, 32'd0);
    cyc(1);
    check("R4 at window", {31'd0, pinFilt[0]}, 32'd1);

    // R10 short pulse is dropped
    pinRaw[1] = 1'b1;
    cyc(2);
    pinRaw[1] = 1'b0;
    cyc(10);
    check("R10 short pulse", {31'd0, pinFilt[1]}, 32'd0);

    // mixed traffic, model compared every cycle
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) pinRaw = NP'($urandom_range(0, 15));
      if ($urandom_range(0, 15) == 0) pinIsDigIn = NP'($urandom_range(0, 15));
    end
    pinIsDigIn = 4'hF;

    // R3 clearing one enable bit
    pinRaw = 4'hF;
    cyc(10);
    check("R3 all high", {28'd0, pinFilt}, 32'hF);
    wr(2'd0, 32'hB);
    cyc(1);
    check("R3 only pin2 cleared", {28'd0, pinFilt}, 32'hB);
    check("R2 disabled low", {31'd0, pinFilt[2]}, 32'd0);

    // R5 qualifier off
    pinIsDigIn = 4'b0111;
    cyc(2);
    check("R5 non-digital pin", {31'd0, pinFilt[3]}, 32'd0);
    pinIsDigIn = 4'hF;
    wr(2'd0, 32'hF);

    // R8 locked selector
    wr(2'd1, 32'd1);
    rd("R8 write ignored", 2'd1, 32'd0);

    // R7 slow tick source
    wr(2'd0, 32'h0);
    wr(2'd1, 32'd1);
    rd("R7 select slow", 2'd1, 32'd1);
    wr(2'd2, 32'd2);
    pinRaw = 4'h0;
    wr(2'd0, 32'hF);
    cyc(80);
    check("R7 settled low", {28'd0, pinFilt}, 32'd0);
    pinRaw = 4'hF;
    cyc(4);
    check("R7 no change without ticks", {28'd0, pinFilt}, 32'd0);
    cyc(100);
    check("R7 change on ticks", {28'd0, pinFilt}, 32'hF);

    // R6 bypass with width 0 on bus clock
    wr(2'd0, 32'h0);
    wr(2'd1, 32'd0);
    wr(2'd2, 32'd0);
    pinRaw = 4'h0;
    wr(2'd0, 32'hF);
    cyc(5);
    pinRaw = 4'h5;
    cyc(2);
    check("R6 before pass", {28'd0, pinFilt}, 32'd0);
    cyc(1);
    check("R6 pass at k+2", {28'd0, pinFilt}, 32'h5);
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      pinRaw = NP'(t);
    end

    // R9 register map and unused bits
    wr(2'd0, 32'h0);
    wr(2'd1, 32'hFFFF_FFFF);
    rd("R9 clksel reserved", 2'd1, 32'd1);
    wr(2'd2, 32'hFFFF_FFFF);
    rd("R9 width bits", 2'd2, 32'hF);
    wr(2'd0, 32'hFFFF_FFFF);
    rd("R9 enable bits", 2'd0, 32'hF);
    rd("R9 spare address", 2'd3, 32'd0);

    // R11 no-filter build
    pinRaw = 4'hF;
    cyc(20);
    for (int a = 0; a < 3; a++) begin
      regAddr = 2'(a);
      #0.2;
      check("R11 reads zero", rdNoFilt, 32'd0);
    end
    check("R11 outputs zero", {28'd0, filtNoFilt}, 32'd0);

    cyc(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule